// File: doc/BRIEF.md
# Shared Cache Event Counter Store

This block keeps the event counters of every L1 cache in a simulated multiprocessor inside one shared synchronous memory. The cache model reports each event by raising an increment request with a cache number and a counter slot. The block then adds one to that entry through a two-cycle read-modify-write. A second increment to the same entry in the very next cycle picks up the value that is being written, so no event is lost. Counters stop at their largest value instead of wrapping.

A free-running scan walks through every entry, one per cycle, and wraps around without end. It exposes the entry index it is reading, which packs the cache number above the slot number. The counter value follows one clock later together with a valid flag. The scan and the increment path share one memory read port. When an increment is accepted it wins the port, and the scan holds its index for that cycle.

Each cache owns eight slots. Five of them count events: store misses (slot 0), load misses (slot 2), store hits (slot 4), store misses that upgrade a read-only copy (slot 5) and load hits (slot 6). The other slots stay at zero. The number of caches and the counter width are parameters.

Top module: `l1_stat_store`

## Requirements
- R1: A reset sets every counter to zero and sets the scan index to 0. `scanValid` is low in the first cycle after reset.
- R2: An entry index is {cache number, slot}, with the slot in the low 3 bits. Slots 0, 2, 4, 5 and 6 count store misses, load misses, store hits, upgrade store misses and load hits.
- R3: An accepted increment adds exactly one to the addressed entry. A scan read issued two or more cycles after the request returns the new value.
- R4: Increments to the same entry in consecutive cycles are all counted. A run of N such increments raises the counter by N.
- R5: A counter at 2^CNT_W-1 stays there when incremented again.
- R6: An increment whose slot is 1, 3 or 7, or whose cache number is NUM_CACHES or more, is ignored. It does not stall the scan. Those entries always read zero.
- R7: In each cycle where `scanFire` is high, the scan index advances by one on the next clock. After entry NUM_CACHES*8-1 it returns to 0.
- R8: One clock after a cycle in which `scanFire` is high, `scanValid` is high and `scanData` holds the counter at the index that was presented.
- R9: In a cycle with an accepted increment, `scanFire` is low, the scan index does not change on the next clock, and `scanValid` is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| incValid | input | 1 | Increment request |
| incCache | input | CID_W | Cache number of the increment |
| incSlot | input | 3 | Counter slot of the increment |
| scanIdx | output | CID_W+3 | Entry index being read by the scan this cycle |
| scanFire | output | 1 | The scan owns the read port this cycle |
| scanData | output | CNT_W | Counter value of the index presented one cycle earlier |
| scanValid | output | 1 | `scanData` is valid |

## Verification
Two functions can fall in the same cycle: an increment and a scan read both want the single read port, and a write-back can meet a new read of the same entry. The bench sends single increments, bursts and random streams with gaps while the scan keeps running. It checks in every cycle that an accepted increment lowers `scanFire` and holds the index, and that an ignored increment does neither. After each stream it runs full quiet sweeps and compares every scanned value with counts computed from the stimulus. Back-to-back bursts to one entry and A/B/A patterns test the forwarding path.

// File: rtl/l1_stat_pkg.sv
package l1_stat_pkg;

  localparam int SLOT_W = 3;
  localparam int SLOTS  = 1 << SLOT_W;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_ST_MISS = 3'd0,
    SLOT_LD_MISS = 3'd2,
    SLOT_ST_HIT  = 3'd4,
    SLOT_UPGRADE = 3'd5,
    SLOT_LD_HIT  = 3'd6
  } slot_e;

  localparam logic [SLOTS-1:0] USED_MASK =
      (SLOTS'(1) << SLOT_ST_MISS) | (SLOTS'(1) << SLOT_LD_MISS) |
      (SLOTS'(1) << SLOT_ST_HIT)  | (SLOTS'(1) << SLOT_UPGRADE) |
      (SLOTS'(1) << SLOT_LD_HIT);

  typedef struct packed {
    logic incRead;
    logic scanRead;
    logic wrEn;
    logic useFwd;
  } stat_ctrl_t;

  function automatic logic slotUsed(input logic [SLOT_W-1:0] s);
    return USED_MASK[s];
  endfunction

endpackage

// File: rtl/l1_stat_ctrl.sv
module l1_stat_ctrl
  import l1_stat_pkg::*;
#(
  parameter int NUM_CACHES = 16,
  parameter int CID_W      = 4,
  parameter int IDX_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              incValid,
  input  logic [CID_W-1:0]  incCache,
  input  logic [SLOT_W-1:0] incSlot,
  input  logic              fwdMatch,
  output stat_ctrl_t        strobes,
  output logic [IDX_W-1:0]  scanIdx,
  output logic              scanFire,
  output logic              scanValid
);

  localparam int DEPTH = NUM_CACHES * SLOTS;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic incOk;
  logic s1Valid;
  logic lastValid;

  assign incOk = incValid && (int'(incCache) < NUM_CACHES) && slotUsed(incSlot);

  assign strobes.incRead  = incOk;
  assign strobes.scanRead = !incOk;
  assign strobes.wrEn     = s1Valid;
  assign strobes.useFwd   = s1Valid && lastValid && fwdMatch;
  assign scanFire         = !incOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      scanIdx   <= '0;
      s1Valid   <= 1'b0;
      lastValid <= 1'b0;
      scanValid <= 1'b0;
    end else begin
      if (!incOk) begin
        scanIdx <= (scanIdx == LAST_IDX) ? '0 : scanIdx + 1'b1;
      end
      s1Valid   <= incOk;
      lastValid <= s1Valid;
      scanValid <= !incOk;
    end
  end

  // R7
  scan_step_chk: assert property (@(posedge clk) disable iff (rst)
    scanFire && scanIdx != LAST_IDX |=> scanIdx == $past(scanIdx) + 1'b1);

  // R7
  scan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    scanFire && scanIdx == LAST_IDX |=> scanIdx == '0);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !scanFire |=> $stable(scanIdx) && !scanValid);

  // R8
  data_lag_chk: assert property (@(posedge clk) disable iff (rst)
    scanFire |=> scanValid);

  // R6
  ignore_chk: assert property (@(posedge clk) disable iff (rst)
    incValid && !slotUsed(incSlot) |-> scanFire);

endmodule

// File: rtl/l1_stat_dpath.sv
module l1_stat_dpath
  import l1_stat_pkg::*;
#(
  parameter int NUM_CACHES = 16,
  parameter int CNT_W      = 16,
  parameter int IDX_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  stat_ctrl_t       strobes,
  input  logic [IDX_W-1:0] incAddr,
  input  logic [IDX_W-1:0] scanIdx,
  output logic [CNT_W-1:0] rdData,
  output logic             fwdMatch
);

  localparam int DEPTH = NUM_CACHES * SLOTS;

  logic [CNT_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] s1Addr;
  logic [IDX_W-1:0] lastAddr;
  logic [CNT_W-1:0] lastData;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] newVal;

  assign fwdMatch = (s1Addr == lastAddr);
  assign base     = strobes.useFwd ? lastData : rdData;
  assign newVal   = (&base) ? base : base + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdData   <= '0;
      s1Addr   <= '0;
      lastAddr <= '0;
      lastData <= '0;
    end else begin
      if (strobes.incRead) begin
        rdData <= mem[incAddr];
        s1Addr <= incAddr;
      end else if (strobes.scanRead) begin
        rdData <= mem[scanIdx];
      end
      if (strobes.wrEn) begin
        mem[s1Addr] <= newVal;
        lastAddr    <= s1Addr;
        lastData    <= newVal;
      end
    end
  end

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.wrEn |=> lastData != '0);

  // R6
  used_slot_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.wrEn |-> slotUsed(s1Addr[SLOT_W-1:0]) &&
                     (int'(s1Addr[IDX_W-1:SLOT_W]) < NUM_CACHES));

  // R4
  fwd_sel_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.wrEn && fwdMatch && $past(strobes.wrEn) |-> strobes.useFwd);

endmodule

// File: rtl/l1_stat_store.sv
module l1_stat_store
  import l1_stat_pkg::*;
#(
  parameter int NUM_CACHES = 16,
  parameter int CNT_W      = 16,
  parameter int CID_W      = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
  parameter int IDX_W      = CID_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              incValid,
  input  logic [CID_W-1:0]  incCache,
  input  logic [SLOT_W-1:0] incSlot,
  output logic [IDX_W-1:0]  scanIdx,
  output logic              scanFire,
  output logic [CNT_W-1:0]  scanData,
  output logic              scanValid
);

  stat_ctrl_t strobes;
  logic       fwdMatch;

  l1_stat_ctrl #(
    .NUM_CACHES(NUM_CACHES), .CID_W(CID_W), .IDX_W(IDX_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .incValid(incValid), .incCache(incCache),
    .incSlot(incSlot), .fwdMatch(fwdMatch), .strobes(strobes),
    .scanIdx(scanIdx), .scanFire(scanFire), .scanValid(scanValid)
  );

  l1_stat_dpath #(
    .NUM_CACHES(NUM_CACHES), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) i_dpath (
    .clk(clk), .rst(rst), .strobes(strobes), .incAddr({incCache, incSlot}),
    .scanIdx(scanIdx), .rdData(scanData), .fwdMatch(fwdMatch)
  );

endmodule

// File: tb/test_l1_stat_store.sv
module test_l1_stat_store;

  localparam int NC    = 3;
  localparam int CW    = 4;
  localparam int CID_W = 2;
  localparam int IDX_W = 5;
  localparam int DEPTH = NC * 8;
  localparam int MAXV  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic incValid = 1'b0;
  logic [CID_W-1:0] incCache = '0;
  logic [2:0] incSlot = '0;
  logic [IDX_W-1:0] scanIdx;
  logic scanFire;
  logic [CW-1:0] scanData;
  logic scanValid;

  int total = 0;
  int fails = 0;
  int model [DEPTH];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  l1_stat_store #(.NUM_CACHES(NC), .CNT_W(CW)) i_l1_stat_store (
    .clk(clk), .rst(rst), .incValid(incValid), .incCache(incCache),
    .incSlot(incSlot), .scanIdx(scanIdx), .scanFire(scanFire),
    .scanData(scanData), .scanValid(scanValid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit usedSlot(input int s);
    return (s == 0) || (s == 2) || (s == 4) || (s == 5) || (s == 6);
  endfunction

  task automatic inc(input int c, input int s);
    logic [IDX_W-1:0] idxB;
    bit ok;
    @(negedge clk);
    incValid = 1'b1;
    incCache = CID_W'(c);
    incSlot  = 3'(s);
    ok = (c < NC) && usedSlot(s);
    #1;
    // R9 stall / R6 no stall for ignored requests
    chk(scanFire == !ok, ok ? "R9 fire" : "R6 fire", int'(scanFire), int'(!ok));
    idxB = scanIdx;
    if (ok && model[c*8+s] < MAXV) model[c*8+s]++;
    @(posedge clk);
    #1;
    if (ok) chk(scanIdx == idxB, "R9 hold", int'(scanIdx), int'(idxB));
    else    chk(int'(scanIdx) == (int'(idxB) + 1) % DEPTH, "R7 step", int'(scanIdx),
                (int'(idxB) + 1) % DEPTH);
  endtask

  task automatic quiet(input int n);
    @(negedge clk);
    incValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep(input string req);
    bit prevFire = 1'b0;
    int prevIdx = 0;
    quiet(2);
    for (int n = 0; n < DEPTH + 2; n++) begin
      @(negedge clk);
      if (prevFire) begin
        chk(scanValid == 1'b1, "R8 valid", int'(scanValid), 1);
        chk(int'(scanData) == model[prevIdx], req, int'(scanData), model[prevIdx]);
        chk(int'(scanIdx) == (prevIdx + 1) % DEPTH, "R7 order", int'(scanIdx),
            (prevIdx + 1) % DEPTH);
      end
      prevFire = scanFire;
      prevIdx  = int'(scanIdx);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    incValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = 0;
    #1;
    // R1
    chk(scanIdx == '0, "R1 idx", int'(scanIdx), 0);
    chk(scanValid == 1'b0, "R1 valid", int'(scanValid), 0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual expired expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    doReset();
    sweep("R1 zero");

    // R2 / R3: one increment per used slot, scaled by cache number
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < 8; s++)
        if (usedSlot(s))
          for (int k = 0; k <= c; k++) begin
            inc(c, s);
            quiet(1);
          end
    sweep("R3 single");

    // R4: back-to-back bursts to one entry
    for (int k = 0; k < 5; k++) inc(1, 2);
    sweep("R4 burst");
    // R4: A/B/A/B interleave
    for (int k = 0; k < 4; k++) begin
      inc(0, 6);
      inc(2, 4);
    end
    sweep("R4 interleave");

    // R6: unused slots and out-of-range cache ignored
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 8; s++)
        if (!usedSlot(s) || c >= NC) inc(c, s);
    sweep("R6 ignored");

    // R5: saturation
    for (int k = 0; k < MAXV + 6; k++) inc(2, 5);
    sweep("R5 saturate");

    // mixed random stream
    doReset();
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      inc(int'(lfsr[1:0]), int'(lfsr[4:2]));
      if (lfsr[5] && lfsr[7]) quiet(0);
    end
    sweep("R3 random");

    // R1: a mid-run reset clears counts
    doReset();
    sweep("R1 clear");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule